// File: doc/BRIEF.md
# Parity-Protected General-Purpose I/O Port

This block is a bus-attached slave that drives a 16-bit parallel output port and samples a 16-bit parallel input port. Each port carries one extra parity line. Software reaches the block over an AHB-Lite interface. It writes a data register to set the output pins and a mode register to choose whether the port acts as an output or an input. Reading the data register returns what the pins show.

On the output side, the block computes a parity line from the driven data. On the input side, it checks the arriving parity line against the sampled pins and raises a registered error flag when the two disagree. A single mode input chooses even or odd parity for both paths. A fault-injection input inverts the result of both parity paths, so that downstream checkers and the error path can be tested on purpose.

The bus side is a small transfer state machine with five states:
- `ST_IDLE`: no data phase is pending.
- `ST_WR_DATA`: a write to the data register is pending.
- `ST_WR_DIR`: a write to the mode register is pending.
- `ST_RD_DATA`: a read of the data register is pending.
- `ST_RD_DIR`: a read of the mode register is pending.

An accepted address phase moves the machine to the matching pending state. Any other cycle, including a phase to an unknown or unaligned address, moves it to `ST_IDLE`. Every state, pending or idle, takes the next accepted address phase directly, so back-to-back transfers need no gap.

Top module: `ahb_pargpio`

## Requirements
- R1: After reset, the output pins are all zero and the port is in input mode. Reading the mode register returns 0, and the parity error flag is low.
- R2: An address phase is accepted only when hsel and hready are high and htrans is NONSEQ (2'b10) or SEQ (2'b11). The register action follows in the next cycle, the data phase. Phases with hsel low, and phases to any address other than exactly 0x0 or 0x4, change no register.
- R3: A write to the data register at 0x0 loads hwdata[15:0] onto the output pins. It does so only when the port is in output mode; in input mode the pins keep their value.
- R4: A write to the mode register at 0x4 selects output mode only when hwdata equals 1. Any other value selects input mode. Reading 0x4 returns 1 in output mode and 0 in input mode.
- R5: Reading 0x0 returns the input pins, zero-extended, in input mode, and returns the output register in output mode. Read data is valid in the data phase.
- R6: With fault injection low, the output parity line makes the count of ones over the 16 output bits plus the parity line even when the parity-mode input is 0, and odd when it is 1.
- R7: With fault injection high, the output parity line is the inverse of the R6 value.
- R8: The parity error flag is a register. In each cycle it takes 1 when the count of ones over the 16 input pins plus the input parity line disagrees with the selected mode (even for 0, odd for 1), and 0 otherwise. Fault injection high inverts this result.
- R9: hreadyout is always 1 and hresp is always 0 (OKAY).
- R10: In back-to-back transfers, a mode write whose data phase overlaps the address phase of a data write applies in time for that data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock |
| hresetn | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| haddr | input | 12 | Byte address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write, 0 for read |
| hready | input | 1 | Bus-wide ready |
| hwdata | input | 32 | Write data (data phase) |
| hreadyout | output | 1 | Slave ready, always high |
| hresp | output | 1 | Response, always OKAY |
| hrdata | output | 32 | Read data (data phase) |
| par_odd | input | 1 | Parity mode: 0 even, 1 odd |
| fault_inj | input | 1 | Inverts both parity paths |
| pin_in | input | 16 | Sampled input port |
| pin_in_par | input | 1 | Parity line arriving with pin_in |
| pin_out | output | 16 | Driven output port |
| pin_out_par | output | 1 | Parity line for pin_out |
| pin_out_en | output | 1 | High while in output mode |
| par_err | output | 1 | Registered input parity mismatch |

## Verification
A corrupted mode bit shows at once: pin_out_en reflects it, and the next read of 0x4 returns it. It also shows one data phase later, when a write to 0x0 is either blocked or applied wrongly. A wrong pending state in the transfer machine appears in the very next cycle, as misplaced read data or as a register change with no matching address phase. A fault in the parity or error path surfaces at the port comparison of pin_out_par within the same cycle, and at par_err one clock after the input pins are sampled.

// File: rtl/ahb_pargpio_pkg.sv
package ahb_pargpio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_DATA,
        ST_WR_DIR,
        ST_RD_DATA,
        ST_RD_DIR
    } bus_state_t;

    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

    localparam int OFF_DATA     = 'h0;
    localparam int OFF_DIR      = 'h4;
    localparam int DIR_OUT_CODE = 1;

endpackage

// File: rtl/gpio_parity_unit.sv
module gpio_parity_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] bits_i,
    input  logic         odd_i,
    input  logic         flip_i,
    output logic         par_o
);
    // Even mode: reduction XOR of the bits. Odd mode inverts it; flip inverts again.
    always_comb begin
        par_o = (^bits_i) ^ odd_i ^ flip_i;
    end
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import ahb_pargpio_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hready,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [ADDR_W-1:0] haddr,
    output logic              wr_data_en,
    output logic              wr_dir_en,
    output logic              rd_data_en,
    output logic              rd_dir_en
);
    bus_state_t state_q, state_d;
    logic       accept;

    always_comb begin
        accept  = hsel && hready && (htrans == HT_NONSEQ || htrans == HT_SEQ);
        state_d = ST_IDLE;
        if (accept) begin
            if (haddr == ADDR_W'(OFF_DATA)) begin
                state_d = hwrite ? ST_WR_DATA : ST_RD_DATA;
            end else if (haddr == ADDR_W'(OFF_DIR)) begin
                state_d = hwrite ? ST_WR_DIR : ST_RD_DIR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        wr_data_en = 1'b0;
        wr_dir_en  = 1'b0;
        rd_data_en = 1'b0;
        rd_dir_en  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_WR_DATA: wr_data_en = 1'b1;
            ST_WR_DIR:  wr_dir_en  = 1'b1;
            ST_RD_DATA: rd_data_en = 1'b1;
            ST_RD_DIR:  rd_dir_en  = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import ahb_pargpio_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BUS_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_data_en,
    input  logic              wr_dir_en,
    input  logic              rd_data_en,
    input  logic              rd_dir_en,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [DATA_W-1:0] pins_in,
    output logic [DATA_W-1:0] out_q,
    output logic              dir_out_q,
    output logic [BUS_W-1:0]  rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q     <= '0;
            dir_out_q <= 1'b0;
        end else begin
            if (wr_dir_en) begin
                dir_out_q <= (wdata == BUS_W'(DIR_OUT_CODE));
            end
            if (wr_data_en && dir_out_q) begin
                out_q <= wdata[DATA_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_data_en) begin
            rdata = dir_out_q ? BUS_W'(out_q) : BUS_W'(pins_in);
        end else if (rd_dir_en) begin
            rdata = BUS_W'(dir_out_q);
        end
    end
endmodule

// File: rtl/ahb_pargpio.sv
module ahb_pargpio #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int BUS_W  = 32
) (
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic              hready,
    input  logic [BUS_W-1:0]  hwdata,
    output logic              hreadyout,
    output logic              hresp,
    output logic [BUS_W-1:0]  hrdata,
    input  logic              par_odd,
    input  logic              fault_inj,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              pin_in_par,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_out_par,
    output logic              pin_out_en,
    output logic              par_err
);
    localparam int CHK_W = DATA_W + 1;

    logic wr_data_en, wr_dir_en, rd_data_en, rd_dir_en;
    logic in_mismatch;

    gpio_bus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (hclk),
        .rst_n      (hresetn),
        .hsel       (hsel),
        .hready     (hready),
        .htrans     (htrans),
        .hwrite     (hwrite),
        .haddr      (haddr),
        .wr_data_en (wr_data_en),
        .wr_dir_en  (wr_dir_en),
        .rd_data_en (rd_data_en),
        .rd_dir_en  (rd_dir_en)
    );

    gpio_regfile #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_regs (
        .clk        (hclk),
        .rst_n      (hresetn),
        .wr_data_en (wr_data_en),
        .wr_dir_en  (wr_dir_en),
        .rd_data_en (rd_data_en),
        .rd_dir_en  (rd_dir_en),
        .wdata      (hwdata),
        .pins_in    (pin_in),
        .out_q      (pin_out),
        .dir_out_q  (pin_out_en),
        .rdata      (hrdata)
    );

    gpio_parity_unit #(.W(DATA_W)) u_gen (
        .bits_i (pin_out),
        .odd_i  (par_odd),
        .flip_i (fault_inj),
        .par_o  (pin_out_par)
    );

    // Over data plus parity line: result is 0 when the count matches the mode.
    gpio_parity_unit #(.W(CHK_W)) u_chk_par (
        .bits_i ({pin_in, pin_in_par}),
        .odd_i  (par_odd),
        .flip_i (fault_inj),
        .par_o  (in_mismatch)
    );

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            par_err <= 1'b0;
        end else begin
            par_err <= in_mismatch;
        end
    end

    assign hreadyout = 1'b1;
    assign hresp     = 1'b0;
endmodule

// File: rtl/ahb_pargpio_chk.sv
module ahb_pargpio_chk #(
    parameter int DATA_W = 16
) (
    input logic              hclk,
    input logic              hresetn,
    input logic              hreadyout,
    input logic              hresp,
    input logic              par_odd,
    input logic              fault_inj,
    input logic [DATA_W-1:0] pin_in,
    input logic              pin_in_par,
    input logic [DATA_W-1:0] pin_out,
    input logic              pin_out_par,
    input logic              pin_out_en,
    input logic              par_err
);
    logic past_valid;

    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) past_valid <= 1'b0;
        else          past_valid <= 1'b1;
    end

    // R9
    a_r9_always_ready: assert property (@(posedge hclk) disable iff (!hresetn)
        hreadyout && !hresp);

    // R6 and R7: total ones over port plus parity line follow mode and fault.
    a_r6_r7_out_parity: assert property (@(posedge hclk) disable iff (!hresetn)
        ($countones({pin_out, pin_out_par}) % 2) == int'(par_odd ^ fault_inj));

    // R8
    a_r8_err_follows_inputs: assert property (@(posedge hclk) disable iff (!hresetn)
        past_valid |-> par_err ==
            (($countones({$past(pin_in), $past(pin_in_par)}) % 2 == 1)
             ^ $past(par_odd) ^ $past(fault_inj)));

    // R3
    a_r3_out_moves_only_when_driven: assert property (@(posedge hclk) disable iff (!hresetn)
        (past_valid && !$stable(pin_out)) |-> $past(pin_out_en));
endmodule

bind ahb_pargpio ahb_pargpio_chk #(.DATA_W(DATA_W)) u_chk (
    .hclk        (hclk),
    .hresetn     (hresetn),
    .hreadyout   (hreadyout),
    .hresp       (hresp),
    .par_odd     (par_odd),
    .fault_inj   (fault_inj),
    .pin_in      (pin_in),
    .pin_in_par  (pin_in_par),
    .pin_out     (pin_out),
    .pin_out_par (pin_out_par),
    .pin_out_en  (pin_out_en),
    .par_err     (par_err)
);

// File: tb/ahb_pargpio_bench.sv
module ahb_pargpio_bench;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int BW = 32;

    localparam int K_PORT = 0;   // {pin_out_par, pin_out}
    localparam int K_RDATA = 1;  // hrdata
    localparam int K_ERR = 2;    // par_err
    localparam int K_RESP = 3;   // {hreadyout, hresp}

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hsel = 1'b0;
    logic [AW-1:0] haddr = '0;
    logic [1:0]    htrans = 2'b00;
    logic          hwrite = 1'b0;
    logic          hready = 1'b1;
    logic [BW-1:0] hwdata = '0;
    logic          hreadyout, hresp;
    logic [BW-1:0] hrdata;
    logic          par_odd = 1'b0;
    logic          fault_inj = 1'b0;
    logic [DW-1:0] pin_in = '0;
    logic          pin_in_par = 1'b0;
    logic [DW-1:0] pin_out;
    logic          pin_out_par, pin_out_en, par_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int          kind;
        logic [31:0] val;
        string       req;
    } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    ahb_pargpio u_ahb_pargpio (
        .hclk(clk), .hresetn(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
        .hwrite(hwrite), .hready(hready), .hwdata(hwdata), .hreadyout(hreadyout),
        .hresp(hresp), .hrdata(hrdata), .par_odd(par_odd), .fault_inj(fault_inj),
        .pin_in(pin_in), .pin_in_par(pin_in_par), .pin_out(pin_out),
        .pin_out_par(pin_out_par), .pin_out_en(pin_out_en), .par_err(par_err)
    );

    function automatic logic odd_ones(input logic [DW:0] v);
        int n = 0;
        for (int i = 0; i <= DW; i++) n += int'(v[i]);
        return logic'(n % 2);
    endfunction

    // Parity line that makes total ones even (mode 0) or odd (mode 1), then fault flip.
    function automatic logic want_par(input logic [DW-1:0] d, input logic odd, input logic flt);
        return odd_ones({1'b0, d}) ^ odd ^ flt;
    endfunction

    task automatic expect_item(input int kind, input logic [31:0] val, input string req);
        exp_t it;
        it.kind = kind;
        it.val  = val;
        it.req  = req;
        sb_q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    // Monitor: pops expected items and compares at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                K_PORT:  act = {15'b0, pin_out_par, pin_out};
                K_RDATA: act = hrdata;
                K_ERR:   act = {31'b0, par_err};
                default: act = {30'b0, hreadyout, hresp};
            endcase
            checks++;
            if (act !== it.val) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", it.req, act, it.val);
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic sel);
        @(negedge clk);
        hsel = sel; haddr = a; htrans = 2'b10; hwrite = 1'b1;
        @(posedge clk); #1;
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
        @(posedge clk); #1;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a);
        @(negedge clk);
        hsel = 1'b1; haddr = a; htrans = 2'b10; hwrite = 1'b0;
        @(posedge clk); #1;
        hsel = 1'b0; htrans = 2'b00;
    endtask

    // Mode write whose data phase overlaps the data write's address phase.
    task automatic bus_dir_then_data(input logic [31:0] d);
        @(negedge clk);
        hsel = 1'b1; haddr = 12'h4; htrans = 2'b10; hwrite = 1'b1;
        @(posedge clk); #1;
        hwdata = 32'd1; haddr = 12'h0; htrans = 2'b11;
        @(posedge clk); #1;
        hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hwdata = d;
        @(posedge clk); #1;
    endtask

    task automatic set_ctl(input logic odd, input logic flt, input logic [DW-1:0] pins, input logic pp);
        @(negedge clk);
        par_odd = odd; fault_inj = flt; pin_in = pins; pin_in_par = pp;
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        expect_item(K_PORT, 32'h0, "R1 port after reset");
        expect_item(K_ERR, 32'h0, "R1 error flag after reset");
        expect_item(K_RESP, 32'h2, "R9 ready/okay");
        bus_rd(12'h4);
        expect_item(K_RDATA, 32'h0, "R1 R4 mode after reset");

        // R3 blocked in input mode
        bus_wr(12'h0, 32'h0000_5A5A, 1'b1);
        expect_item(K_PORT, 32'h0, "R3 write blocked in input mode");

        // R2 unselected and unaligned phases ignored
        bus_wr(12'h4, 32'h1, 1'b0);
        bus_rd(12'h4);
        expect_item(K_RDATA, 32'h0, "R2 hsel low ignored");
        bus_wr(12'h6, 32'h1, 1'b1);
        bus_rd(12'h4);
        expect_item(K_RDATA, 32'h0, "R2 unaligned address ignored");

        // R4 output mode
        bus_wr(12'h4, 32'h1, 1'b1);
        bus_rd(12'h4);
        expect_item(K_RDATA, 32'h1, "R4 mode reads 1");

        // R3 R6 output data and parity
        bus_wr(12'h0, 32'hFFFF_A5A5, 1'b1);
        expect_item(K_PORT, {15'b0, want_par(16'hA5A5, 1'b0, 1'b0), 16'hA5A5}, "R3 R6 even A5A5");
        bus_wr(12'h0, 32'h0000_0001, 1'b1);
        expect_item(K_PORT, {15'b0, want_par(16'h0001, 1'b0, 1'b0), 16'h0001}, "R6 even 0001");
        set_ctl(1'b1, 1'b0, 16'h0, 1'b1);
        expect_item(K_PORT, {15'b0, want_par(16'h0001, 1'b1, 1'b0), 16'h0001}, "R6 odd 0001");
        set_ctl(1'b1, 1'b1, 16'h0, 1'b1);
        expect_item(K_PORT, {15'b0, want_par(16'h0001, 1'b1, 1'b1), 16'h0001}, "R7 fault odd");
        set_ctl(1'b0, 1'b1, 16'h0, 1'b0);
        expect_item(K_PORT, {15'b0, want_par(16'h0001, 1'b0, 1'b1), 16'h0001}, "R7 fault even");
        set_ctl(1'b0, 1'b0, 16'hBEEF, 1'b0);

        // R5 read in output mode returns output register
        bus_rd(12'h0);
        expect_item(K_RDATA, 32'h0000_0001, "R5 read in output mode");

        // R4 value 2 means input
        bus_wr(12'h4, 32'h2, 1'b1);
        bus_rd(12'h4);
        expect_item(K_RDATA, 32'h0, "R4 value 2 selects input");
        bus_wr(12'h0, 32'h0000_1234, 1'b1);
        expect_item(K_PORT, {15'b0, want_par(16'h0001, 1'b0, 1'b0), 16'h0001}, "R3 held after mode 2");

        // R5 read in input mode returns pins
        bus_rd(12'h0);
        expect_item(K_RDATA, 32'h0000_BEEF, "R5 read in input mode");

        // R8 input parity check (BEEF has 13 ones)
        set_ctl(1'b0, 1'b0, 16'hBEEF, 1'b1);
        expect_item(K_ERR, {31'b0, odd_ones({16'hBEEF, 1'b1}) ^ 1'b0}, "R8 even good");
        set_ctl(1'b0, 1'b0, 16'hBEEF, 1'b0);
        expect_item(K_ERR, {31'b0, odd_ones({16'hBEEF, 1'b0}) ^ 1'b0}, "R8 even bad");
        set_ctl(1'b1, 1'b0, 16'hBEEF, 1'b0);
        expect_item(K_ERR, {31'b0, ~odd_ones({16'hBEEF, 1'b0})}, "R8 odd good");
        set_ctl(1'b1, 1'b1, 16'hBEEF, 1'b0);
        expect_item(K_ERR, 32'h1, "R8 fault forces error");
        set_ctl(1'b0, 1'b0, 16'h0003, 1'b0);
        expect_item(K_ERR, 32'h0, "R8 even good 0003");

        // R10 back-to-back mode then data
        bus_dir_then_data(32'h0000_00F0);
        expect_item(K_PORT, {15'b0, want_par(16'h00F0, 1'b0, 1'b0), 16'h00F0}, "R10 pipelined write");
        bus_rd(12'h4);
        expect_item(K_RDATA, 32'h1, "R10 mode after pipelined write");

        expect_item(K_RESP, 32'h2, "R9 ready/okay at end");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule